// File: doc/BRIEF.md
# Clear-on-Compare Timer with Toggle Output

This block is a 16-bit up-counter that runs in clear-on-compare mode. The counter climbs once per timer tick. When it reaches a TOP value, it returns to zero on the next tick. TOP comes from one of two registers, and a waveform-mode code picks which one: the compare-A register or the capture register. The timer tick comes from a prescaler, which divides the core clock by 1, 8, 64, 256 or 1024, or stops the count. A waveform level can flip on every match, so the output is a square wave with a half-period of N·(TOP+1) clocks. That level reaches the pin only when the direction bit drives it.

TOP registers are compared live and are not double-buffered. If software writes a TOP below the current count, the counter misses the match. It runs on to 0xFFFF, wraps to zero and raises the overflow flag, and only after that can it match the new TOP. A small state machine follows whether the counter sits at or below TOP (ST_CLIMB), above TOP (ST_OVERRUN), or is stopped (ST_HALT). ST_HALT goes to ST_CLIMB or ST_OVERRUN when the prescaler and mode allow counting. ST_CLIMB goes to ST_OVERRUN when TOP is lowered below the count or the count is written above TOP. ST_OVERRUN returns to ST_CLIMB once the wrap, or a raised TOP, brings the count back to TOP or below. Any state goes to ST_HALT when counting is disabled. The state is re-evaluated every cycle from the next count and the next TOP.

Top module: `ctc_timer16`

## Requirements
- R1: After reset, the count, both TOP registers, all three flags, the waveform level and the pin are 0.
- R2: With wave_mode = 4, compare-A is TOP. At a tick where the count equals TOP, the count becomes 0; at other ticks it increments. With out_mode = 1 the pin toggles every N·(TOP+1) clocks.
- R3: With wave_mode = 12, the capture register is TOP and compare-A has no effect on the period.
- R4: clk_sel codes 1, 2, 3, 4 and 5 give a tick every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop the counter, and the count holds.
- R5: A match sets cmpa_flag in mode 4 and cap_flag in mode 12, on the same edge on which the count returns to 0. The other flag is left alone.
- R6: A TOP write takes effect at once. If the new TOP is below the count, no match happens until the count has passed 0xFFFF and wrapped to 0 and then climbed to the new TOP.
- R7: ovf_flag sets on the edge where a tick moves the count from 0xFFFF to 0x0000.
- R8: The waveform level toggles on a match only when out_mode = 1. With any other out_mode value it holds, while the flags still set.
- R9: wave_pin equals the waveform level when pin_dir = 1, and is 0 when pin_dir = 0.
- R10: Flags are sticky. Writing 1 to flag_clr bit 0 clears cmpa_flag, bit 1 clears cap_flag and bit 2 clears ovf_flag. A set in the same cycle wins over a clear.
- R11: cnt_we loads cnt_wdata into the count on the next edge. It takes priority over a tick, and no match or overflow comes from that cycle.
- R12: A wave_mode other than 4 or 12 halts the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Prescaler code (0 stop, 1..5 divide, 6..7 stop) |
| wave_mode | input | 4 | TOP source: 4 compare-A, 12 capture, other values halt |
| out_mode | input | 2 | Waveform action on a match: 1 toggles, other values hold |
| pin_dir | input | 1 | 1 drives the waveform onto the pin |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write value |
| cmpa_we | input | 1 | Compare-A write strobe |
| cmpa_wdata | input | 16 | Compare-A write value |
| cap_we | input | 1 | Capture register write strobe |
| cap_wdata | input | 16 | Capture register write value |
| flag_clr | input | 3 | Write-one-to-clear: bit0 compare-A, bit1 capture, bit2 overflow |
| count_o | output | 16 | Current count |
| cmpa_flag | output | 1 | Compare-A match flag |
| cap_flag | output | 1 | Capture-TOP match flag |
| ovf_flag | output | 1 | Overflow flag |
| wave_pin | output | 1 | Gated waveform output |

## Verification
All results are registered. A write or flag clear applied before a rising edge shows on count_o and the flags after that edge, and a match changes count_o, the flag and the pin on the same edge. The bench drives on one falling edge and checks on the next, so each sample falls one full edge after its cause. Toggle periods are timed as the number of falling edges between pin changes, and the first change after each reconfiguration is discarded as alignment. The wraparound case is counted out arithmetically: the count is expected to reach 0xFFFF exactly 65535 minus the starting count cycles after the TOP write.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    localparam int          CTC_CNT_W     = 16;
    localparam int          CTC_PRE_W     = 10;
    localparam int          CTC_NFLAG     = 3;
    localparam logic [3:0]  MODE_TOP_CMPA = 4'd4;
    localparam logic [3:0]  MODE_TOP_CAP  = 4'd12;
    localparam logic [1:0]  OUT_TOGGLE    = 2'd1;

    // flag bit positions shared by flag_clr and the flag bank
    localparam int FLG_CMPA = 0;
    localparam int FLG_CAP  = 1;
    localparam int FLG_OVF  = 2;

    typedef enum logic [1:0] {
        ST_HALT    = 2'd0,
        ST_CLIMB   = 2'd1,
        ST_OVERRUN = 2'd2
    } run_state_e;

endpackage

// File: rtl/ctc_prescaler.sv
module ctc_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       run,
    output logic       tick
);

    logic [PRE_W-1:0] limit;
    logic [PRE_W-1:0] pre_q;

    // terminal value of the divider for each code
    always_comb begin
        run   = 1'b1;
        limit = '0;
        unique case (sel)
            3'd1:    limit = '0;
            3'd2:    limit = PRE_W'(7);
            3'd3:    limit = PRE_W'(63);
            3'd4:    limit = PRE_W'(255);
            3'd5:    limit = PRE_W'(1023);
            default: run   = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || pre_q >= limit) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && (pre_q == limit);

endmodule

// File: rtl/ctc_count_fsm.sv
module ctc_count_fsm
    import ctc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] top_q,
    input  logic [CNT_W-1:0] top_nxt,
    output logic [CNT_W-1:0] count_q,
    output logic             match,
    output logic             wrap,
    output run_state_e       state_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    run_state_e       state_d;
    logic             step;
    logic             at_top;
    logic [CNT_W-1:0] count_d;

    assign at_top = (count_q == top_q);

    // output process: what this cycle's tick does in each state
    always_comb begin
        step  = 1'b0;
        match = 1'b0;
        wrap  = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                step = 1'b0;
            end
            ST_CLIMB: begin
                step  = tick && !cnt_we;
                match = step && at_top;
                wrap  = step && (count_q == CNT_MAX);
            end
            ST_OVERRUN: begin
                // above TOP: only the run to the wrap is possible
                step  = tick && !cnt_we;
                wrap  = step && (count_q == CNT_MAX);
            end
        endcase
    end

    always_comb begin
        if (cnt_we) begin
            count_d = cnt_wdata;
        end else if (match) begin
            count_d = '0;
        end else if (step) begin
            count_d = count_q + 1'b1;
        end else begin
            count_d = count_q;
        end
    end

    // transition process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (go) begin
                    state_d = (count_d > top_nxt) ? ST_OVERRUN : ST_CLIMB;
                end
            end
            ST_CLIMB: begin
                if (!go) begin
                    state_d = ST_HALT;
                end else if (count_d > top_nxt) begin
                    state_d = ST_OVERRUN;
                end
            end
            ST_OVERRUN: begin
                if (!go) begin
                    state_d = ST_HALT;
                end else if (count_d <= top_nxt) begin
                    state_d = ST_CLIMB;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

endmodule

// File: rtl/ctc_flags.sv
module ctc_flags #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_v,
    input  logic [NFLAG-1:0] clr_v,
    output logic [NFLAG-1:0] flag_q
);

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_v[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_v[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ctc_wave.sv
module ctc_wave
    import ctc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match,
    input  logic [1:0] out_mode,
    input  logic       pin_dir,
    output logic       wave_lvl,
    output logic       wave_pin
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_lvl <= 1'b0;
        end else if (match && out_mode == OUT_TOGGLE) begin
            wave_lvl <= !wave_lvl;
        end
    end

    assign wave_pin = pin_dir && wave_lvl;

endmodule

// File: rtl/ctc_timer16.sv
module ctc_timer16
    import ctc_pkg::*;
#(
    parameter int CNT_W = CTC_CNT_W,
    parameter int PRE_W = CTC_PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       clk_sel,
    input  logic [3:0]       wave_mode,
    input  logic [1:0]       out_mode,
    input  logic             pin_dir,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cmpa_we,
    input  logic [CNT_W-1:0] cmpa_wdata,
    input  logic             cap_we,
    input  logic [CNT_W-1:0] cap_wdata,
    input  logic [2:0]       flag_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             cmpa_flag,
    output logic             cap_flag,
    output logic             ovf_flag,
    output logic             wave_pin
);

    logic [CNT_W-1:0]     cmpa_q, cap_q, cmpa_nxt, cap_nxt;
    logic [CNT_W-1:0]     top_q, top_nxt;
    logic                 mode_ok, cap_mode, pre_run, tick, go;
    logic                 match, wrap, wave_lvl;
    logic [CTC_NFLAG-1:0] flag_set, flag_q;
    run_state_e           run_state;

    assign cmpa_nxt = cmpa_we ? cmpa_wdata : cmpa_q;
    assign cap_nxt  = cap_we  ? cap_wdata  : cap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpa_q <= '0;
            cap_q  <= '0;
        end else begin
            cmpa_q <= cmpa_nxt;
            cap_q  <= cap_nxt;
        end
    end

    assign cap_mode = (wave_mode == MODE_TOP_CAP);
    assign mode_ok  = cap_mode || (wave_mode == MODE_TOP_CMPA);
    assign top_q    = cap_mode ? cap_q   : cmpa_q;
    assign top_nxt  = cap_mode ? cap_nxt : cmpa_nxt;
    assign go       = pre_run && mode_ok;

    ctc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .run   (pre_run),
        .tick  (tick)
    );

    ctc_count_fsm #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .tick      (tick),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .top_q     (top_q),
        .top_nxt   (top_nxt),
        .count_q   (count_o),
        .match     (match),
        .wrap      (wrap),
        .state_q   (run_state)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLG_CMPA] = match && !cap_mode;
        flag_set[FLG_CAP]  = match && cap_mode;
        flag_set[FLG_OVF]  = wrap;
    end

    ctc_flags #(.NFLAG(CTC_NFLAG)) u_flg (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (flag_set),
        .clr_v  (flag_clr),
        .flag_q (flag_q)
    );

    assign cmpa_flag = flag_q[FLG_CMPA];
    assign cap_flag  = flag_q[FLG_CAP];
    assign ovf_flag  = flag_q[FLG_OVF];

    ctc_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .out_mode (out_mode),
        .pin_dir  (pin_dir),
        .wave_lvl (wave_lvl),
        .wave_pin (wave_pin)
    );

endmodule

// File: rtl/ctc_timer16_chk.sv
module ctc_timer16_chk
    import ctc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       clk_sel,
    input logic             cnt_we,
    input logic [2:0]       flag_clr,
    input logic             pin_dir,
    input logic [1:0]       out_mode,
    input logic [3:0]       wave_mode,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] top_q,
    input logic             cmpa_flag,
    input logic             ovf_flag,
    input logic             wave_pin,
    input logic             wave_lvl,
    input run_state_e       state_q
);

    // R7
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count_o == '0) && ($past(count_o) == '1));

    // R9
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_dir |-> !wave_pin);

    // R4
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0 && !cnt_we) |=> $stable(count_o));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpa_flag && !flag_clr[FLG_CMPA]) |=> cmpa_flag);

    // R8
    wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode != OUT_TOGGLE) |=> $stable(wave_lvl));

    // R5
    cmpa_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmpa_flag) |-> ($past(wave_mode) == MODE_TOP_CMPA) && (count_o == '0 || $past(cnt_we)));

    // R6
    overrun_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OVERRUN) |-> (count_o > top_q));

endmodule

bind ctc_timer16 ctc_timer16_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_sel   (clk_sel),
    .cnt_we    (cnt_we),
    .flag_clr  (flag_clr),
    .pin_dir   (pin_dir),
    .out_mode  (out_mode),
    .wave_mode (wave_mode),
    .count_o   (count_o),
    .top_q     (top_q),
    .cmpa_flag (cmpa_flag),
    .ovf_flag  (ovf_flag),
    .wave_pin  (wave_pin),
    .wave_lvl  (wave_lvl),
    .state_q   (run_state)
);

// File: tb/sim_ctc_timer16.sv
module sim_ctc_timer16;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  clk_sel;
    logic [3:0]  wave_mode;
    logic [1:0]  out_mode;
    logic        pin_dir;
    logic        cnt_we;
    logic [15:0] cnt_wdata;
    logic        cmpa_we;
    logic [15:0] cmpa_wdata;
    logic        cap_we;
    logic [15:0] cap_wdata;
    logic [2:0]  flag_clr;
    logic [15:0] count_o;
    logic        cmpa_flag, cap_flag, ovf_flag, wave_pin;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = !clk;

    ctc_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_mode(wave_mode),
        .out_mode(out_mode), .pin_dir(pin_dir), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cmpa_we(cmpa_we), .cmpa_wdata(cmpa_wdata), .cap_we(cap_we), .cap_wdata(cap_wdata),
        .flag_clr(flag_clr), .count_o(count_o), .cmpa_flag(cmpa_flag), .cap_flag(cap_flag),
        .ovf_flag(ovf_flag), .wave_pin(wave_pin)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    function automatic int divider(input logic [2:0] sel);
        case (sel)
            3'd1:    return 1;
            3'd2:    return 8;
            3'd3:    return 64;
            3'd4:    return 256;
            3'd5:    return 1024;
            default: return 0;
        endcase
    endfunction

    // TOP registers, count cleared and flags cleared in one write cycle
    task automatic configure(input logic [3:0] mode, input logic [2:0] sel,
                             input logic [15:0] a, input logic [15:0] c);
        @(negedge clk);
        wave_mode = mode; clk_sel = sel;
        cmpa_we = 1'b1; cmpa_wdata = a;
        cap_we  = 1'b1; cap_wdata  = c;
        cnt_we  = 1'b1; cnt_wdata  = 16'd0;
        flag_clr = 3'b111;
        @(negedge clk);
        cmpa_we = 1'b0; cap_we = 1'b0; cnt_we = 1'b0; flag_clr = 3'b000;
    endtask

    task automatic wait_pin_change(output int cycles);
        logic prev;
        prev = wave_pin;
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (wave_pin == prev && cycles < 5000);
    endtask

    task automatic period_case(input string req, input logic [3:0] mode,
                               input logic [2:0] sel, input int t);
        int c;
        int exp_half;
        exp_half = divider(sel) * (t + 1);
        if (mode == 4'd12) configure(mode, sel, 16'(t + 3), 16'(t));
        else               configure(mode, sel, 16'(t), 16'(t + 5));
        wait_pin_change(c);
        for (int k = 0; k < 2; k++) begin
            wait_pin_change(c);
            check(req, c, exp_half);
        end
        if (mode == 4'd12) begin
            check("R5 capture flag in capture mode", cap_flag, 1);
            check("R5 compare-A flag idle in capture mode", cmpa_flag, 0);
        end else begin
            check("R5 compare-A flag in compare mode", cmpa_flag, 1);
            check("R5 capture flag idle in compare mode", cap_flag, 0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        summary();
        $finish;
    end

    initial begin
        int c;
        logic hold;
        logic [15:0] snap;
        int bad;

        rst_n = 1'b0; clk_sel = 3'd0; wave_mode = 4'd0; out_mode = 2'd0; pin_dir = 1'b0;
        cnt_we = 1'b0; cnt_wdata = '0; cmpa_we = 1'b0; cmpa_wdata = '0;
        cap_we = 1'b0; cap_wdata = '0; flag_clr = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 count after reset", count_o, 0);
        check("R1 flags after reset", {ovf_flag, cap_flag, cmpa_flag}, 0);
        check("R1 pin after reset", wave_pin, 0);

        pin_dir = 1'b1;
        out_mode = 2'd1;

        // R2 and R4: compare-A TOP sweep over divide codes
        for (int s = 1; s <= 3; s++) begin
            for (int ti = 0; ti < 4; ti++) begin
                int tv;
                tv = (ti == 3) ? 6 : ti;
                period_case("R2 R4 half-period compare-A", 4'd4, 3'(s), tv);
            end
        end
        period_case("R4 half-period divide 256", 4'd4, 3'd4, 1);
        period_case("R4 half-period divide 1024", 4'd4, 3'd5, 0);

        // R3: capture TOP
        period_case("R3 half-period capture TOP", 4'd12, 3'd1, 2);
        period_case("R3 half-period capture TOP", 4'd12, 3'd1, 5);
        period_case("R3 half-period capture TOP", 4'd12, 3'd2, 3);

        // R9: direction gating
        configure(4'd4, 3'd1, 16'd0, 16'd0);
        pin_dir = 1'b0;
        bad = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (wave_pin !== 1'b0) bad++;
        end
        check("R9 pin low while not driven", bad, 0);
        pin_dir = 1'b1;
        wait_pin_change(c);
        wait_pin_change(c);
        check("R9 pin toggles when driven", c, 1);

        // R8: non-toggle output modes hold the level
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            out_mode = 2'(m);
            @(negedge clk);
            flag_clr = 3'b111;
            @(negedge clk);
            flag_clr = 3'b000;
            hold = wave_pin;
            bad = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (wave_pin !== hold) bad++;
            end
            check("R8 level holds when not toggling", bad, 0);
            check("R8 match still sets flag", cmpa_flag, 1);
        end
        out_mode = 2'd1;

        // R4: stop codes hold the count
        configure(4'd4, 3'd1, 16'd1000, 16'd0);
        repeat (10) @(negedge clk);
        for (int z = 0; z < 3; z++) begin
            clk_sel = (z == 0) ? 3'd0 : ((z == 1) ? 3'd6 : 3'd7);
            @(negedge clk);
            snap = count_o;
            repeat (30) @(negedge clk);
            check("R4 stop code holds count", count_o, snap);
        end
        clk_sel = 3'd1;
        repeat (5) @(negedge clk);
        check("R4 count resumes", count_o > snap, 1);

        // R12: unsupported wave_mode halts
        wave_mode = 4'd0;
        @(negedge clk);
        snap = count_o;
        repeat (30) @(negedge clk);
        check("R12 other mode halts count", count_o, snap);
        wave_mode = 4'd4;

        // R11: count write
        @(negedge clk);
        cnt_we = 1'b1; cnt_wdata = 16'd500;
        @(negedge clk);
        cnt_we = 1'b0;
        check("R11 count loaded", count_o, 500);
        @(negedge clk);
        check("R11 count climbs from loaded value", count_o, 501);

        // R6 R7 R10: TOP lowered below the count
        configure(4'd4, 3'd1, 16'd300, 16'd0);
        while (count_o != 16'd250) @(negedge clk);
        cmpa_we = 1'b1; cmpa_wdata = 16'd100; flag_clr = 3'b111;
        @(negedge clk);
        cmpa_we = 1'b0; flag_clr = 3'b000;
        check("R6 count keeps climbing past new TOP", count_o, 251);
        repeat (65535 - 251) @(negedge clk);
        check("R6 count reaches all-ones", count_o, 16'hFFFF);
        check("R7 overflow not yet set", ovf_flag, 0);
        check("R6 no match before wrap", cmpa_flag, 0);
        @(negedge clk);
        check("R7 count wrapped", count_o, 0);
        check("R7 overflow set at wrap", ovf_flag, 1);
        repeat (50) @(negedge clk);
        check("R10 overflow sticky", ovf_flag, 1);
        repeat (50) @(negedge clk);
        check("R6 count at new TOP", count_o, 100);
        check("R6 no match yet", cmpa_flag, 0);
        @(negedge clk);
        check("R6 cleared after new TOP", count_o, 0);
        check("R6 match after wrap", cmpa_flag, 1);
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        check("R10 compare-A flag cleared", cmpa_flag, 0);
        check("R10 overflow untouched by other clear bit", ovf_flag, 1);

        summary();
        $finish;
    end

endmodule